// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped controller for a bank of general-purpose pins, 94 of them by default. Software reaches it through a plain 32-bit register port with a byte address, a write strobe and a combinational read-data bus. Two kinds of register sit behind that port. A bitmap class packs one bit per pin, 32 pins to a word. A per-pin class gives every pin a pair of 32-bit configuration words at an 8-byte stride starting at 0x100.

On the pin side the block drives an output level, an output enable, a native-or-GPIO select and a weak-pull code for each pin. It brings each input through a two-stage synchroniser. While sensing is enabled, the synchronised level reads back in the first configuration word and also appears on a per-pin sensed output that downstream interrupt logic can use. A separate global word selects which of two system interrupt lines the bank reports on. A pin-ownership bitmap loads from a parameter at reset, and software can read it back.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin is an input in native mode with input sensing disabled. Output level is 0 and pull code is 0, so `pin_oe`, `pin_out`, `pin_gpio_sel` and `pin_pull` are all zero, and `irq_line_sel` is 0. Configuration word 1 and configuration word 2 of every pin each read 0x00000004.
- R2: The ownership word for pin p is at 0x00 + (p/32)*4, at bit p mod 32 (1 = free for general use, 0 = reserved for firmware). It resets to the OWN_RESET parameter and can be written and read. Bits at or above the pin count always read 0.
- R3: Configuration word 1 of pin p is at 0x100 + 8p. Bit 31 is the output level, bit 2 is the direction (0 = output, 1 = input) and bit 0 is the usage select (0 = native, 1 = GPIO). The stored bits read back as written. Every bit other than 31, 30, 2 and 0 reads 0.
- R4: `pin_out[p]` follows bit 31 of word 1 and `pin_gpio_sel[p]` follows bit 0. `pin_oe[p]` is 1 exactly when the pin is in GPIO mode with direction output. All of these take effect from the clock edge that accepts the write.
- R5: Configuration word 2 of pin p is at 0x104 + 8p. Bit 2 set disables input sensing, and bits 1:0 hold the pull code, which drives `pin_pull[2p+1:2p]`. Other bits read 0.
- R6: With sensing enabled, a change on `pin_in[p]` set up before clock edge k shows in word 1 bit 30 and on `pin_sensed[p]` after edge k+1, and not after edge k alone.
- R7: While sensing is disabled for a pin, bit 30 of its word 1 and `pin_sensed[p]` read 0 whatever the input level.
- R8: Bit 30 of word 1 is read-only. Writing 1 or 0 there does not change what it reads.
- R9: The global control word at 0x7C holds bit 0, which drives `irq_line_sel`. Its other bits read 0.
- R10: Unmapped addresses read 0, and writes to them change no register and no pin output. Unmapped addresses include 0x80, the bitmap word after the last one (0x0C by default), and the configuration pair past the last pin (0x3F0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPIN | Raw pin input levels |
| pin_out | output | NPIN | Driven output level per pin |
| pin_oe | output | NPIN | Output enable per pin |
| pin_gpio_sel | output | NPIN | 1 = pin used as GPIO, 0 = native function |
| pin_pull | output | 2*NPIN | Weak-pull code, two bits per pin |
| pin_sensed | output | NPIN | Synchronised input, gated by sense enable |
| irq_line_sel | output | 1 | Selects one of two system interrupt lines |

## Verification
The assertions assume that `bus_addr` is word aligned and that `bus_wr` lasts one clock per access. They also assume that `pin_in` is stable at each sampling edge, so the synchroniser relation can be stated exactly. The bench changes `bus_addr`, `bus_wdata`, `bus_wr` and `pin_in` only on the falling edge and uses only multiples of four as addresses. The synchroniser checks therefore see a clean two-edge delay from the input change to the readback.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPIN = 94,
  parameter int ADDR_W = 12,
  parameter logic [NPIN-1:0] OWN_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_gpio_sel,
  output logic [2*NPIN-1:0] pin_pull,
  output logic [NPIN-1:0]   pin_sensed,
  output logic              irq_line_sel
);
  localparam int NWORD = (NPIN + 31) / 32;
  localparam int BM_W  = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] CFG_BASE  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] GCTL_ADDR = ADDR_W'('h7C);
  localparam logic [ADDR_W-3:0] NWORD_A   = (ADDR_W-2)'(NWORD);
  localparam logic [IDX_W-1:0]  NPIN_A    = IDX_W'(NPIN);
  localparam logic [NWORD*32-1:0] OWN_INIT = (NWORD*32)'(OWN_RESET);
  localparam logic [NWORD*32-1:0] VALID    = {(NWORD*32){1'b1}} >> (NWORD*32 - NPIN);

  logic [31:0]       own_w [NWORD];
  logic [NPIN-1:0]   out_lvl, dir_in, use_gpio, sense_dis;
  logic [2*NPIN-1:0] pull;
  logic [NPIN-1:0]   sync1, sync2;
  logic              gsel;

  logic [ADDR_W-3:0] bm_word;
  logic [BM_W-1:0]   bm_idx;
  logic              bm_hit, gctl_hit, cfg_hit, cfg_hi;
  logic [ADDR_W-1:0] cfg_off;
  logic [IDX_W-1:0]  cfg_idx;
  logic [PIN_W-1:0]  cfg_pin;
  logic [NPIN-1:0]   sampled;

  assign bm_word  = bus_addr[ADDR_W-1:2];
  assign bm_idx   = bm_word[BM_W-1:0];
  assign bm_hit   = bm_word < NWORD_A;
  assign gctl_hit = bus_addr == GCTL_ADDR;
  assign cfg_off  = bus_addr - CFG_BASE;
  assign cfg_idx  = cfg_off[ADDR_W-1:3];
  assign cfg_hit  = (bus_addr >= CFG_BASE) && (cfg_idx < NPIN_A);
  assign cfg_pin  = cfg_idx[PIN_W-1:0];
  assign cfg_hi   = bus_addr[2];

  assign sampled      = sync2 & ~sense_dis;
  assign pin_sensed   = sampled;
  assign pin_out      = out_lvl;
  assign pin_gpio_sel = use_gpio;
  assign pin_oe       = use_gpio & ~dir_in;
  assign pin_pull     = pull;
  assign irq_line_sel = gsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORD; w++) own_w[w] <= OWN_INIT[w*32 +: 32];
      out_lvl   <= '0;
      dir_in    <= '1;
      use_gpio  <= '0;
      sense_dis <= '1;
      pull      <= '0;
      gsel      <= 1'b0;
    end else if (bus_wr) begin
      if (bm_hit) begin
        own_w[bm_idx] <= bus_wdata & VALID[bm_idx*32 +: 32];
      end else if (gctl_hit) begin
        gsel <= bus_wdata[0];
      end else if (cfg_hit) begin
        if (!cfg_hi) begin
          out_lvl[cfg_pin]  <= bus_wdata[31];
          dir_in[cfg_pin]   <= bus_wdata[2];
          use_gpio[cfg_pin] <= bus_wdata[0];
        end else begin
          sense_dis[cfg_pin]      <= bus_wdata[2];
          pull[{cfg_pin, 1'b0} +: 2] <= bus_wdata[1:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bm_hit) begin
      bus_rdata = own_w[bm_idx];
    end else if (gctl_hit) begin
      bus_rdata[0] = gsel;
    end else if (cfg_hit) begin
      if (!cfg_hi) begin
        bus_rdata[31] = out_lvl[cfg_pin];
        bus_rdata[30] = sampled[cfg_pin];
        bus_rdata[2]  = dir_in[cfg_pin];
        bus_rdata[0]  = use_gpio[cfg_pin];
      end else begin
        bus_rdata[2]   = sense_dis[cfg_pin];
        bus_rdata[1:0] = pull[{cfg_pin, 1'b0} +: 2];
      end
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPIN = 94,
  parameter int ADDR_W = 12,
  parameter int PIN_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_sensed,
  input logic              irq_line_sel,
  input logic              cfg_hit,
  input logic              cfg_hi,
  input logic [PIN_W-1:0]  cfg_pin,
  input logic [NPIN-1:0]   sense_dis
);
  localparam int NWORD = (NPIN + 31) / 32;
  localparam int TOP   = NPIN - (NWORD - 1) * 32;

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r6_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (pin_sensed == ($past(pin_in, 2) & ~sense_dis)));

  a_r4_out_level_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cfg_hit && !cfg_hi) |=> (pin_out[$past(cfg_pin)] == $past(bus_wdata[31])));

  a_r9_line_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'('h7C)) |=> $stable(irq_line_sel));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h80)) |-> (bus_rdata == 32'h0));

  generate
    if (TOP < 32) begin : g_pad
      a_r2_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'((NWORD - 1) * 4)) |-> (bus_rdata[31:TOP] == '0));
    end
  endgenerate
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_sensed(pin_sensed), .irq_line_sel(irq_line_sel),
  .cfg_hit(cfg_hit), .cfg_hi(cfg_hi), .cfg_pin(cfg_pin), .sense_dis(sense_dis)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int NPIN = 94;
  localparam int ADDR_W = 12;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPIN-1:0]   pin_in = '0;
  logic [NPIN-1:0]   pin_out, pin_oe, pin_gpio_sel, pin_sensed;
  logic [2*NPIN-1:0] pin_pull;
  logic              irq_line_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  gpio_bank #(.NPIN(NPIN), .ADDR_W(ADDR_W),
              .OWN_RESET(94'h2AAA_AAAA_DEAD_BEEF_1234_5678)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_gpio_sel(pin_gpio_sel),
    .pin_pull(pin_pull), .pin_sensed(pin_sensed), .irq_line_sel(irq_line_sel));

  always #5 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] c1(int p);
    return ADDR_W'(32'h100 + p * 8);
  endfunction

  function automatic logic [ADDR_W-1:0] c2(int p);
    return ADDR_W'(32'h104 + p * 8);
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk("R1", "pin_oe zero", 32'(pin_oe != 0), 0);
    chk("R1", "pin_out zero", 32'(pin_out != 0), 0);
    chk("R1", "gpio_sel zero", 32'(pin_gpio_sel != 0), 0);
    chk("R1", "pull zero", 32'(pin_pull != 0), 0);
    chk("R1", "line sel", 32'(irq_line_sel), 0);
    rd(c1(0), d);  chk("R1", "cfg1 pin0", d, 32'h4);
    rd(c2(93), d); chk("R1", "cfg2 pin93", d, 32'h4);
    rd(12'h000, d); chk("R2", "own word0 reset", d, 32'h1234_5678);
    rd(12'h004, d); chk("R2", "own word1 reset", d, 32'hDEAD_BEEF);
    rd(12'h008, d); chk("R2", "own word2 reset", d, 32'h2AAA_AAAA);
  endtask

  task automatic t_own;
    logic [31:0] d;
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R2", "own word2 pad bits", d, 32'h3FFF_FFFF);
    wr(12'h004, 32'h0);
    rd(12'h004, d); chk("R2", "own word1 cleared", d, 32'h0);
  endtask

  task automatic t_cfg1;
    logic [31:0] d;
    wr(c1(5), 32'h8000_0005);
    #1;
    chk("R4", "pin5 out", 32'(pin_out[5]), 1);
    chk("R4", "pin5 oe input", 32'(pin_oe[5]), 0);
    chk("R4", "pin5 gpio", 32'(pin_gpio_sel[5]), 1);
    rd(c1(5), d); chk("R3", "cfg1 pin5 readback", d, 32'h8000_0005);
    wr(c1(5), 32'h8000_0001);
    #1 chk("R4", "pin5 oe output", 32'(pin_oe[5]), 1);
    wr(c1(93), 32'h0000_0001);
    #1;
    chk("R4", "pin93 oe", 32'(pin_oe[93]), 1);
    chk("R4", "pin93 out", 32'(pin_out[93]), 0);
    wr(c1(7), 32'h7FFF_FFFA);
    rd(c1(7), d); chk("R3", "cfg1 pin7 unused bits", d, 32'h0);
    #1 chk("R4", "pin7 native oe", 32'(pin_oe[7]), 0);
  endtask

  task automatic t_cfg2;
    logic [31:0] d;
    wr(c2(40), 32'hFFFF_FFFB);
    rd(c2(40), d); chk("R5", "cfg2 pin40", d, 32'h3);
    #1 chk("R5", "pin40 pull", 32'(pin_pull[81:80]), 3);
    chk("R5", "pin39 pull", 32'(pin_pull[79:78]), 0);
  endtask

  task automatic t_sense;
    logic [31:0] d;
    @(negedge clk); pin_in[40] = 1;
    @(posedge clk);
    rd(c1(40), d); chk("R6", "bit30 after one edge", 32'(d[30]), 0);
    chk("R6", "sensed after one edge", 32'(pin_sensed[40]), 0);
    @(posedge clk);
    rd(c1(40), d); chk("R6", "bit30 after two edges", 32'(d[30]), 1);
    chk("R6", "sensed after two edges", 32'(pin_sensed[40]), 1);
    pin_in[41] = 1;
    repeat (3) @(posedge clk);
    rd(c1(41), d); chk("R7", "pin41 sensing off bit30", 32'(d[30]), 0);
    chk("R7", "pin41 sensed", 32'(pin_sensed[41]), 0);
    wr(c2(40), 32'h4);
    rd(c1(40), d); chk("R7", "pin40 sensing disabled bit30", 32'(d[30]), 0);
    chk("R7", "pin40 sensed disabled", 32'(pin_sensed[40]), 0);
    wr(c2(40), 32'h0);
  endtask

  task automatic t_ro;
    logic [31:0] d;
    wr(c1(40), 32'h0000_0004);
    rd(c1(40), d); chk("R8", "bit30 high stays", d, 32'h4000_0004);
    @(negedge clk); pin_in[40] = 0;
    repeat (3) @(posedge clk);
    wr(c1(40), 32'h4000_0004);
    rd(c1(40), d); chk("R8", "bit30 write ignored", d, 32'h0000_0004);
  endtask

  task automatic t_gctl;
    logic [31:0] d;
    wr(12'h07C, 32'hFFFF_FFFF);
    rd(12'h07C, d); chk("R9", "gctl readback", d, 32'h1);
    chk("R9", "line sel set", 32'(irq_line_sel), 1);
    wr(12'h07C, 32'h0);
    #1 chk("R9", "line sel clear", 32'(irq_line_sel), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [NPIN-1:0] oe0, out0;
    logic [2*NPIN-1:0] pu0;
    #1; oe0 = pin_oe; out0 = pin_out; pu0 = pin_pull;
    wr(12'h080, 32'hFFFF_FFFF);
    rd(12'h080, d); chk("R10", "addr 0x80", d, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, d); chk("R10", "addr 0x0C", d, 32'h0);
    wr(c1(94), 32'hFFFF_FFFF);
    wr(c2(94), 32'hFFFF_FFFF);
    rd(c1(94), d); chk("R10", "pair past last pin", d, 32'h0);
    #1;
    chk("R10", "oe unchanged", 32'(pin_oe != oe0), 0);
    chk("R10", "out unchanged", 32'(pin_out != out0), 0);
    chk("R10", "pull unchanged", 32'(pin_pull != pu0), 0);
    rd(12'h008, d); chk("R10", "own word2 intact", d, 32'h3FFF_FFFF);
    rd(12'h07C, d); chk("R10", "gctl intact", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_own();
    t_cfg1();
    t_cfg2();
    t_sense();
    t_ro();
    t_gctl();
    t_unmapped();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule